// File: doc/BRIEF.md
# Slot-Timing Clock Prescaler

This block turns a system clock of 1 to 128 MHz into a one-cycle tick enable at about 1 MHz. Downstream single-wire bus slot timers count that tick. It has no data path, only a control byte and a tick strobe, so it has no valid/ready interface. The 8-bit control value `div_cfg_i` is held by the surrounding register logic and read directly by this block.

The divide ratio is an odd predivider (1, 3, 5 or 7) times a power of two (1 to 128). Bit 7 of the control value gates the whole divider. While that bit is clear the tick stays low and both counters stay cleared. A new divisor written while the divider runs is held back until the current period ends, so the tick spacing never shrinks in the middle of a period.

Top module: `slot_tick_prescaler`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `tick_o` is 0.
- R2: The ratio R equals odd × 2^exp. The odd factor comes from `div_cfg_i[1:0]`: 00→1, 01→3, 10→5, 11→7. The exponent comes from `div_cfg_i[4:2]`. For example, 0x85 gives 6, 0x8D gives 24, 0x93 gives 112 and 0x9C gives 128.
- R3: Suppose a clock edge samples bit 7 set while the divider is stopped. The first tick is then high in the cycle that begins R−1 edges after that edge. Each later tick follows the previous one by exactly R cycles, and each tick lasts one cycle.
- R4: When `div_cfg_i[7]` is 0, `tick_o` is 0 in that same cycle. The divider stops at the next edge. When it is enabled again, counting restarts from zero.
- R5: With ratio 1 (0x80), `tick_o` is high in every enabled cycle after the enabling edge.
- R6: A divisor changed while the divider runs takes effect at the edge that ends the current tick cycle. The period in progress completes with the old ratio.
- R7: Bits 6:5 of `div_cfg_i` have no effect on the tick.
- R8: Between two ticks of one uninterrupted run, the spacing is never less than the ratio that was in force for that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg_i | input | 8 | Control value: bit 7 enable, bits 4:2 exponent, bits 1:0 odd select |
| tick_o | output | 1 | One-cycle tick enable at the divided rate |

## Verification
`tick_o` is combinational from the registered counters and the live enable bit. A cleared enable therefore shows at the output 1 ns after the bench drives it. A rising enable is seen at the next clock edge, and the first tick follows R−1 edges after that. The bench drives `div_cfg_i` just after each falling edge and compares `tick_o` 1 ns later against a single-counter reference model. The model advances on each rising edge from the same sampled inputs, so every check lands in the cycle in which the result is due. A few directed checks also count cycles to the first tick by hand, and they confirm the continuous tick at ratio 1.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int ODD_SEL_W = 2;
  localparam int EXP_W     = 3;
  localparam int EN_BIT    = 7;
  localparam int RATIO_W   = ODD_SEL_W + 1 + (1 << EXP_W) - 1;

  typedef struct packed {
    logic [EXP_W-1:0]     exp;
    logic [ODD_SEL_W-1:0] sel;
  } div_fields_t;

  function automatic logic [RATIO_W-1:0] ratio_of(div_fields_t f);
    logic [RATIO_W-1:0] odd;
    odd = RATIO_W'({f.sel, 1'b1});
    return odd << f.exp;
  endfunction
endpackage

// File: rtl/div_cfg_hold.sv
module div_cfg_hold
  import prescale_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  div_fields_t fields_i,
  input  logic        tick_i,
  output logic        run_o,
  output div_fields_t active_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o    <= 1'b0;
      active_o <= '0;
    end else begin
      run_o <= en_i;
      if (!run_o || tick_i) active_o <= fields_i;
    end
  end

  AST_HOLD_MIDCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && en_i && !tick_i) |=> $stable(active_o)); // R6
endmodule

// File: rtl/odd_stage.sv
module odd_stage #(
  parameter int SEL_W = 2,
  localparam int CNT_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_val;

  assign top_val = {sel_i, 1'b0};
  assign last_o  = (cnt_q == top_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_ODD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= top_val); // R2
endmodule

// File: rtl/pow2_stage.sv
module pow2_stage #(
  parameter int EXP_W = 3,
  localparam int CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             last_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  assign mask   = ~({CNT_W{1'b1}} << exp_i);
  assign last_o = (cnt_q == mask);
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  AST_POW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= mask); // R2
endmodule

// File: rtl/slot_tick_prescaler.sv
module slot_tick_prescaler
  import prescale_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] div_cfg_i,
  output logic       tick_o
);
  logic        en;
  logic        run;
  logic        clr;
  logic        odd_last;
  logic        pow_last;
  logic        pow_zero;
  div_fields_t fields;
  div_fields_t active;

  assign en     = div_cfg_i[EN_BIT];
  assign fields = div_cfg_i[ODD_SEL_W+EXP_W-1:0];
  assign clr    = !run || !en;
  assign tick_o = run && en && odd_last && pow_last;

  div_cfg_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .fields_i (fields),
    .tick_i   (tick_o),
    .run_o    (run),
    .active_o (active)
  );

  odd_stage #(.SEL_W(ODD_SEL_W)) u_odd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .sel_i  (active.sel),
    .last_o (odd_last)
  );

  pow2_stage #(.EXP_W(EXP_W)) u_pow (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .step_i (odd_last),
    .exp_i  (active.exp),
    .last_o (pow_last),
    .zero_o (pow_zero)
  );

  // Spacing monitor used only by the assertions below
  logic [RATIO_W-1:0] gap_q;
  logic               seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!run) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= RATIO_W'(1);
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && seen_q) |-> (gap_q == ratio_of(active))); // R8
  AST_FIRST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !seen_q) |-> (gap_q == ratio_of(active) - 1'b1)); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> pow_zero); // R4
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick_o); // R1
endmodule

// File: tb/slot_tick_prescaler_bench.sv
module slot_tick_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       tick;

  int n_checks = 0;
  int n_fail   = 0;

  bit         m_run = 1'b0;
  int         m_cnt = 0;
  int         m_ratio = 1;

  always #10 clk = ~clk;

  slot_tick_prescaler u_slot_tick_prescaler (
    .clk(clk), .rst_n(rst_n), .div_cfg_i(cfg), .tick_o(tick)
  );

  function automatic int ratio_fn(logic [7:0] c);
    return (2 * int'(c[1:0]) + 1) << c[4:2];
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tick actual=%0b expected=%0b cfg=%02h t=%0t",
               req, act, exp, cfg, $time);
    end
  endtask

  // one cycle: check 1 ns after the falling edge, advance model at rising edge
  task automatic step(string req);
    logic exp_t;
    #1;
    exp_t = m_run && cfg[7] && (m_cnt == m_ratio - 1);
    check(req, tick, exp_t);
    @(posedge clk);
    if (rst_n) begin
      if (!m_run) begin
        m_ratio = ratio_fn(cfg); m_cnt = 0; m_run = cfg[7];
      end else if (!cfg[7]) begin
        m_run = 1'b0; m_cnt = 0;
      end else if (m_cnt == m_ratio - 1) begin
        m_cnt = 0; m_ratio = ratio_fn(cfg);
      end else begin
        m_cnt++;
      end
    end
    @(negedge clk);
  endtask

  task automatic steps(string req, int n);
    for (int i = 0; i < n; i++) step(req);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd1234));
    @(negedge clk);
    cfg = 8'h80;
    steps("R1", 4);               // reset held: tick stays low
    rst_n = 1'b1;
    step("R1");                   // first cycle after release
    steps("R5", 3);

    // R5: ratio 1 ticks every cycle
    cfg = 8'h00; steps("R4", 2);
    cfg = 8'h80; step("R5");
    for (int i = 0; i < 8; i++) begin
      #1; check("R5", tick, 1'b1); @(negedge clk); m_cnt = 0;
    end
    cfg = 8'h00; steps("R4", 2);

    // R2: every field combination, two periods each
    for (int c = 0; c < 32; c++) begin
      cfg = 8'h00; steps("R4", 2);
      cfg = 8'h80 | 8'(c);
      steps("R2", 2 * ratio_fn(cfg) + 2);
    end

    // R3: explicit count to first tick for 0x93 (112)
    cfg = 8'h00; steps("R4", 2);
    cfg = 8'h93; step("R3");
    cyc = 0;
    while (!tick && cyc < 300) begin
      @(negedge clk); #1; cyc++;
    end
    n_checks++;
    if (cyc != 111) begin
      n_fail++;
      $display("FAIL R3: edges to first tick actual=%0d expected=111", cyc);
    end
    @(negedge clk);
    m_run = 1'b1; m_ratio = 112; m_cnt = 0;   // the tick edge has just passed
    steps("R3", 230);

    // R4: clear mid-count, tick must stay low, restart from zero
    cfg = 8'h85; steps("R4", 4);
    cfg = 8'h05; steps("R4", 20);
    cfg = 8'h85; steps("R4", 15);

    // R6: rewrite mid-period from 24 to 3
    cfg = 8'h00; steps("R4", 2);
    cfg = 8'h8D; steps("R6", 10);
    cfg = 8'h81; steps("R6", 30);

    // R7: bits 6:5 ignored (0xE2 behaves as ratio 5)
    cfg = 8'h00; steps("R4", 2);
    cfg = 8'hE2; steps("R7", 25);
    cfg = 8'hA2; steps("R7", 25);

    // R8: random mix against the reference model
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 59) == 0) begin
        cfg = 8'($urandom);
        if ($urandom_range(0, 7) != 0) cfg[7] = 1'b1;
      end
      step("R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule